// File: doc/BRIEF.md
# Phase History Configuration Lookup

This block keeps a small fully associative table of cache configurations, one for each execution phase it has seen, keyed by a phase identifier. When a request names a phase that is already in the table, the stored configuration comes back on the cycle after the request and no further work is done.

When the phase is new, the block measures how far its miss rate lies from the miss rate of a reference phase. That phase distance goes out on a lookup port to an external distance-window table, and the block waits. The window table answers with one signed log2 step for each cache parameter: size, associativity and line length. The block adds each step to the reference phase's parameter, clamps the sum to the legal range, reports the result and stores it in its table. Later runs of the same phase then hit. Once the table is full, new phases overwrite entries in round-robin order.

Each configuration field holds a log2 index. Size runs from 0 = 2 KB to 2 = 8 KB, associativity from 0 = direct-mapped to 2 = 4-way, and line length from 0 = 16 B to 2 = 64 B.

Top module: `phase_cfg_lookup`

## Requirements
- R1: After reset, cfg_valid_o, cfg_hit_o, busy_o and win_req_o are all 0, and the table is empty, so the first request for any phase ID misses.
- R2: A request accepted while busy_o is 0, for a phase ID held in the table, gives cfg_valid_o=1 and cfg_hit_o=1 in the next cycle with the stored fields, and raises no window request.
- R3: A request accepted while busy_o is 0, for a phase ID not in the table, gives win_req_o=1 and busy_o=1 in the next cycle, with win_dist_o equal to the absolute difference between req_mr_i and base_mr_i as sampled with the request.
- R4: While busy_o is 1 and win_ack_i is 0, win_req_o stays 1 and win_dist_o holds its value.
- R5: The cycle after win_ack_i is sampled high while busy, the block gives cfg_valid_o=1, cfg_hit_o=0 and busy_o=0. Each output field equals the reference field captured with the request plus the matching two's-complement step (win_dsize_i, win_dassoc_i, win_dline_i).
- R6: Any sum below 0 is output as 0, and any sum above the field maximum (2 for every field by default) is output as that maximum.
- R7: The estimated configuration is written under the phase ID. A later request for that ID hits with the same fields, whatever its miss rate.
- R8: req_valid_i has no effect while busy_o is 1: no cfg_valid_o follows it, and the ID it carries is not inserted.
- R9: Inserts fill the entries in order. Once all ENTRIES slots are full, each new phase replaces the oldest inserted entry, so the evicted ID misses afterwards and the other IDs still hit.
- R10: Changes on base_mr_i and the base_*_i fields while busy_o is 1 affect neither win_dist_o nor the configuration that results.
- R11: win_ack_i has no effect while busy_o is 0, so no cfg_valid_o follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Phase lookup request |
| req_id_i | input | ID_W | Phase identifier |
| req_mr_i | input | MR_W | Fixed-point miss rate of the phase |
| base_mr_i | input | MR_W | Miss rate of the reference phase |
| base_size_i | input | LOG_W | Reference cache size, log2 index |
| base_assoc_i | input | LOG_W | Reference associativity, log2 index |
| base_line_i | input | LOG_W | Reference line length, log2 index |
| win_req_o | output | 1 | Window lookup request, held until acknowledged |
| win_dist_o | output | MR_W | Phase distance sent to the window table |
| win_ack_i | input | 1 | Window response valid |
| win_dsize_i | input | STEP_W | Signed log2 step for size |
| win_dassoc_i | input | STEP_W | Signed log2 step for associativity |
| win_dline_i | input | STEP_W | Signed log2 step for line length |
| busy_o | output | 1 | Miss in progress; requests are ignored |
| cfg_valid_o | output | 1 | One-cycle pulse: configuration fields are valid |
| cfg_hit_o | output | 1 | 1 for a stored configuration, 0 for a new estimate |
| cfg_size_o | output | LOG_W | Configured size index |
| cfg_assoc_o | output | LOG_W | Configured associativity index |
| cfg_line_o | output | LOG_W | Configured line length index |

## Verification
The bench targets these corner cases:

- **Clamping.** It drives steps that push fields past 0 and past the maximum. A design that wraps instead of clamping returns an illegal index, such as 3 or a value that has wrapped around.
- **Round-robin replacement.** After the table fills, it checks that the oldest ID is evicted. A design with the wrong pointer either evicts a recent phase, which then misses, or keeps the stale one, which then hits.
- **Inputs that must be ignored.** It sends requests while busy, acknowledges while idle, and changes the reference inputs during a miss. A design that obeys any of these emits a spurious configuration, inserts a phase that was never estimated, or computes the result from the wrong reference values.
- **Distance symmetry.** Random miss rates fall on both sides of the reference. This catches a distance computed without taking the absolute value.

// File: rtl/phc_pkg.sv
`timescale 1ns/1ps
package phc_pkg;
  localparam int LOG_W   = 2;  // width of one log2 config field
  localparam int NFIELDS = 3;  // size, assoc, line

  typedef struct packed {
    logic [LOG_W-1:0] line_l2;
    logic [LOG_W-1:0] assoc_l2;
    logic [LOG_W-1:0] size_l2;
  } cfg_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} ctl_state_e;
endpackage

// File: rtl/phc_dist.sv
`timescale 1ns/1ps
module phc_dist #(
  parameter int MR_W = 12
) (
  input  logic [MR_W-1:0] a_i,
  input  logic [MR_W-1:0] b_i,
  output logic [MR_W-1:0] dist_o
);
  always_comb begin
    if (a_i >= b_i) dist_o = a_i - b_i;
    else            dist_o = b_i - a_i;
  end
endmodule

// File: rtl/phc_cfg_apply.sv
`timescale 1ns/1ps
module phc_cfg_apply #(
  parameter int LOG_W   = 2,
  parameter int STEP_W  = 3,
  parameter int NFIELDS = 3,
  parameter logic [NFIELDS*LOG_W-1:0] MAX_VEC = '1
) (
  input  logic [NFIELDS*LOG_W-1:0]  base_i,
  input  logic [NFIELDS*STEP_W-1:0] step_i,
  output logic [NFIELDS*LOG_W-1:0]  cfg_o
);
  localparam int WIDE  = (LOG_W + 1 > STEP_W) ? LOG_W + 1 : STEP_W;
  localparam int SUM_W = WIDE + 1;

  for (genvar f = 0; f < NFIELDS; f++) begin : g_field
    logic [SUM_W-1:0] base_ext, step_ext, sum;
    logic [SUM_W-1:0] max_ext;
    logic [LOG_W-1:0] step_sign_unused;
    assign step_sign_unused = '0;
    assign base_ext = {{(SUM_W-LOG_W){1'b0}}, base_i[f*LOG_W +: LOG_W]};
    assign step_ext = {{(SUM_W-STEP_W){step_i[f*STEP_W+STEP_W-1]}}, step_i[f*STEP_W +: STEP_W]};
    assign max_ext  = {{(SUM_W-LOG_W){1'b0}}, MAX_VEC[f*LOG_W +: LOG_W]};
    assign sum      = base_ext + step_ext;
    always_comb begin
      if (sum[SUM_W-1])      cfg_o[f*LOG_W +: LOG_W] = step_sign_unused;
      else if (sum > max_ext) cfg_o[f*LOG_W +: LOG_W] = MAX_VEC[f*LOG_W +: LOG_W];
      else                    cfg_o[f*LOG_W +: LOG_W] = sum[LOG_W-1:0];
    end
  end
endmodule

// File: rtl/phc_history_table.sv
`timescale 1ns/1ps
module phc_history_table
  import phc_pkg::*;
#(
  parameter int ID_W    = 6,
  parameter int ENTRIES = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ID_W-1:0] look_id_i,
  output logic            look_hit_o,
  output cfg_t            look_cfg_o,
  input  logic            wr_en_i,
  input  logic [ID_W-1:0] wr_id_i,
  input  cfg_t            wr_cfg_i
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q;
  logic [ID_W-1:0]    id_q  [ENTRIES];
  cfg_t               cfg_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;
  logic [ENTRIES-1:0] match;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign match[e] = vld_q[e] && (id_q[e] == look_id_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[e] <= 1'b0;
        id_q[e]  <= '0;
        cfg_q[e] <= '0;
      end else if (wr_en_i && (rr_q == IDX_W'(e))) begin
        vld_q[e] <= 1'b1;
        id_q[e]  <= wr_id_i;
        cfg_q[e] <= wr_cfg_i;
      end
    end
  end

  always_comb begin
    look_cfg_o = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (match[e]) look_cfg_o = look_cfg_o | cfg_q[e];
    end
  end
  assign look_hit_o = |match;

  // single pointer: sequential fill, then oldest-first replacement
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (wr_en_i) begin
      if (rr_q == IDX_W'(ENTRIES-1)) rr_q <= '0;
      else                           rr_q <= rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/phase_cfg_lookup.sv
`timescale 1ns/1ps
module phase_cfg_lookup
  import phc_pkg::*;
#(
  parameter int ID_W      = 6,
  parameter int MR_W      = 12,
  parameter int ENTRIES   = 8,
  parameter int STEP_W    = 3,
  parameter int MAX_SIZE  = 2,
  parameter int MAX_ASSOC = 2,
  parameter int MAX_LINE  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [ID_W-1:0]          req_id_i,
  input  logic [MR_W-1:0]          req_mr_i,
  input  logic [MR_W-1:0]          base_mr_i,
  input  logic [phc_pkg::LOG_W-1:0] base_size_i,
  input  logic [phc_pkg::LOG_W-1:0] base_assoc_i,
  input  logic [phc_pkg::LOG_W-1:0] base_line_i,
  output logic                     win_req_o,
  output logic [MR_W-1:0]          win_dist_o,
  input  logic                     win_ack_i,
  input  logic [STEP_W-1:0]        win_dsize_i,
  input  logic [STEP_W-1:0]        win_dassoc_i,
  input  logic [STEP_W-1:0]        win_dline_i,
  output logic                     busy_o,
  output logic                     cfg_valid_o,
  output logic                     cfg_hit_o,
  output logic [phc_pkg::LOG_W-1:0] cfg_size_o,
  output logic [phc_pkg::LOG_W-1:0] cfg_assoc_o,
  output logic [phc_pkg::LOG_W-1:0] cfg_line_o
);
  localparam logic [NFIELDS*LOG_W-1:0] MAX_VEC =
    {LOG_W'(MAX_LINE), LOG_W'(MAX_ASSOC), LOG_W'(MAX_SIZE)};

  ctl_state_e      state_q;
  logic [ID_W-1:0] pend_id_q;
  cfg_t            base_q;
  logic [MR_W-1:0] dist_q;
  logic            vld_q, hit_q;
  cfg_t            out_q;

  logic            tbl_hit;
  cfg_t            tbl_cfg;
  logic [MR_W-1:0] dist_now;
  logic [NFIELDS*LOG_W-1:0] est_vec;
  cfg_t            est_cfg;
  logic            accept, finish;

  assign accept = (state_q == ST_IDLE) && req_valid_i;
  assign finish = (state_q == ST_WAIT) && win_ack_i;

  phc_history_table #(.ID_W(ID_W), .ENTRIES(ENTRIES)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .look_id_i (req_id_i),
    .look_hit_o(tbl_hit),
    .look_cfg_o(tbl_cfg),
    .wr_en_i   (finish),
    .wr_id_i   (pend_id_q),
    .wr_cfg_i  (est_cfg)
  );

  phc_dist #(.MR_W(MR_W)) u_dist (
    .a_i   (req_mr_i),
    .b_i   (base_mr_i),
    .dist_o(dist_now)
  );

  phc_cfg_apply #(
    .LOG_W(LOG_W), .STEP_W(STEP_W), .NFIELDS(NFIELDS), .MAX_VEC(MAX_VEC)
  ) u_apply (
    .base_i({base_q.line_l2, base_q.assoc_l2, base_q.size_l2}),
    .step_i({win_dline_i, win_dassoc_i, win_dsize_i}),
    .cfg_o (est_vec)
  );

  assign est_cfg.size_l2  = est_vec[0*LOG_W +: LOG_W];
  assign est_cfg.assoc_l2 = est_vec[1*LOG_W +: LOG_W];
  assign est_cfg.line_l2  = est_vec[2*LOG_W +: LOG_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pend_id_q <= '0;
      base_q    <= '0;
      dist_q    <= '0;
    end else if (accept && !tbl_hit) begin
      state_q          <= ST_WAIT;
      pend_id_q        <= req_id_i;
      base_q.size_l2   <= base_size_i;
      base_q.assoc_l2  <= base_assoc_i;
      base_q.line_l2   <= base_line_i;
      dist_q           <= dist_now;
    end else if (finish) begin
      state_q <= ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      hit_q <= 1'b0;
      out_q <= '0;
    end else begin
      vld_q <= 1'b0;
      if (accept && tbl_hit) begin
        vld_q <= 1'b1;
        hit_q <= 1'b1;
        out_q <= tbl_cfg;
      end else if (finish) begin
        vld_q <= 1'b1;
        hit_q <= 1'b0;
        out_q <= est_cfg;
      end
    end
  end

  assign busy_o      = (state_q == ST_WAIT);
  assign win_req_o   = (state_q == ST_WAIT);
  assign win_dist_o  = dist_q;
  assign cfg_valid_o = vld_q;
  assign cfg_hit_o   = vld_q & hit_q;
  assign cfg_size_o  = out_q.size_l2;
  assign cfg_assoc_o = out_q.assoc_l2;
  assign cfg_line_o  = out_q.line_l2;
endmodule

// File: rtl/phc_checker.sv
`timescale 1ns/1ps
module phc_checker #(
  parameter int MR_W      = 12,
  parameter int LOG_W     = 2,
  parameter int MAX_SIZE  = 2,
  parameter int MAX_ASSOC = 2,
  parameter int MAX_LINE  = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             win_ack_i,
  input logic             busy_o,
  input logic             win_req_o,
  input logic [MR_W-1:0]  win_dist_o,
  input logic             cfg_valid_o,
  input logic             cfg_hit_o,
  input logic [LOG_W-1:0] cfg_size_o,
  input logic [LOG_W-1:0] cfg_assoc_o,
  input logic [LOG_W-1:0] cfg_line_o
);
  assert_idle_req_answers_R2_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o) |=> ((cfg_valid_o && cfg_hit_o) || (win_req_o && busy_o && !cfg_valid_o)));

  assert_wait_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !win_ack_i) |=> (busy_o && win_req_o && $stable(win_dist_o) && !cfg_valid_o));

  assert_ack_completes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && win_ack_i) |=> (cfg_valid_o && !cfg_hit_o && !busy_o));

  assert_fields_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |-> (cfg_size_o <= LOG_W'(MAX_SIZE) && cfg_assoc_o <= LOG_W'(MAX_ASSOC)
                     && cfg_line_o <= LOG_W'(MAX_LINE)));

  assert_no_spurious_valid_R8_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i && !(busy_o && win_ack_i)) |=> !cfg_valid_o);
endmodule

bind phase_cfg_lookup phc_checker #(
  .MR_W(MR_W), .LOG_W(phc_pkg::LOG_W),
  .MAX_SIZE(MAX_SIZE), .MAX_ASSOC(MAX_ASSOC), .MAX_LINE(MAX_LINE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .win_ack_i  (win_ack_i),
  .busy_o     (busy_o),
  .win_req_o  (win_req_o),
  .win_dist_o (win_dist_o),
  .cfg_valid_o(cfg_valid_o),
  .cfg_hit_o  (cfg_hit_o),
  .cfg_size_o (cfg_size_o),
  .cfg_assoc_o(cfg_assoc_o),
  .cfg_line_o (cfg_line_o)
);

// File: tb/sim_phase_cfg_lookup.sv
`timescale 1ns/1ps
module sim_phase_cfg_lookup;
  localparam int ID_W = 6, MR_W = 12, ENTRIES = 8, STEP_W = 3, LW = 2, MX = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 0; logic [ID_W-1:0] req_id = '0; logic [MR_W-1:0] req_mr = '0;
  logic [MR_W-1:0] base_mr = '0; logic [LW-1:0] b_s = '0, b_a = '0, b_l = '0;
  logic win_req; logic [MR_W-1:0] win_dist; logic win_ack = 0;
  logic [STEP_W-1:0] d_s = '0, d_a = '0, d_l = '0;
  logic busy, cfg_valid, cfg_hit; logic [LW-1:0] c_s, c_a, c_l;

  phase_cfg_lookup u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_id_i(req_id), .req_mr_i(req_mr),
    .base_mr_i(base_mr), .base_size_i(b_s), .base_assoc_i(b_a), .base_line_i(b_l),
    .win_req_o(win_req), .win_dist_o(win_dist), .win_ack_i(win_ack),
    .win_dsize_i(d_s), .win_dassoc_i(d_a), .win_dline_i(d_l), .busy_o(busy),
    .cfg_valid_o(cfg_valid), .cfg_hit_o(cfg_hit),
    .cfg_size_o(c_s), .cfg_assoc_o(c_a), .cfg_line_o(c_l));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  logic            m_v  [ENTRIES];
  logic [ID_W-1:0] m_id [ENTRIES];
  int              m_cfg[ENTRIES][3];
  int              rr = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int find(input logic [ID_W-1:0] id);
    for (int e = 0; e < ENTRIES; e++) if (m_v[e] && m_id[e] == id) return e;
    return -1;
  endfunction

  function automatic int clampf(input int b, input int s);
    int r = b + s;
    if (r < 0) return 0;
    if (r > MX) return MX;
    return r;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_ni = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    for (int e = 0; e < ENTRIES; e++) m_v[e] = 0;
    rr = 0;
  endtask

  // one phase run; delay = cycles before ack; ign_id sent while busy if ign
  task automatic run_phase(input logic [ID_W-1:0] id, input logic [MR_W-1:0] mr,
                           input int delay, input int ss, input int sa, input int sl,
                           input bit ign, input logic [ID_W-1:0] ign_id, input string tag);
    int k, eb_s, eb_a, eb_l, ed, es, ea, el;
    k = find(id);
    @(negedge clk);
    req_valid = 1; req_id = id; req_mr = mr;
    eb_s = b_s; eb_a = b_a; eb_l = b_l;
    ed = (mr >= base_mr) ? mr - base_mr : base_mr - mr;
    @(posedge clk); #1; req_valid = 0;
    if (k >= 0) begin
      chk(cfg_valid && cfg_hit && !win_req, tag, "hit response", {cfg_valid, cfg_hit, win_req}, 3'b110);
      chk(c_s == m_cfg[k][0] && c_a == m_cfg[k][1] && c_l == m_cfg[k][2], "R7", "stored cfg",
          {c_l, c_a, c_s}, m_cfg[k][2]*16 + m_cfg[k][1]*4 + m_cfg[k][0]);
    end else begin
      chk(win_req && busy && !cfg_valid, tag, "miss response", {win_req, busy, cfg_valid}, 3'b110);
      chk(win_dist == ed, "R3", "distance", win_dist, ed);
      for (int w = 0; w < delay; w++) begin
        @(negedge clk);
        base_mr = MR_W'($urandom); b_s = LW'($urandom % 3); b_a = LW'($urandom % 3); b_l = LW'($urandom % 3);
        if (ign && w == 0) begin req_valid = 1; req_id = ign_id; req_mr = MR_W'($urandom); end
        @(posedge clk); #1; req_valid = 0;
        chk(win_req && busy && win_dist == ed, "R4", "hold while waiting", win_dist, ed);
        chk(!cfg_valid, "R8", "no response while busy", cfg_valid, 0);
      end
      @(negedge clk);
      win_ack = 1; d_s = STEP_W'(ss); d_a = STEP_W'(sa); d_l = STEP_W'(sl);
      @(posedge clk); #1; win_ack = 0;
      es = clampf(eb_s, ss); ea = clampf(eb_a, sa); el = clampf(eb_l, sl);
      chk(cfg_valid && !cfg_hit && !busy, "R5", "estimate response", {cfg_valid, cfg_hit, busy}, 3'b100);
      chk(c_s == es && c_a == ea && c_l == el, "R5 R6 R10", "estimate fields",
          {c_l, c_a, c_s}, el*16 + ea*4 + es);
      m_v[rr] = 1; m_id[rr] = id; m_cfg[rr][0] = es; m_cfg[rr][1] = ea; m_cfg[rr][2] = el;
      rr = (rr + 1) % ENTRIES;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int e = 0; e < ENTRIES; e++) m_v[e] = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    #1;
    chk(!cfg_valid && !cfg_hit && !busy && !win_req, "R1", "reset outputs",
        {cfg_valid, cfg_hit, busy, win_req}, 0);

    // R1 first request misses; R3 distance; R5 apply; R7 later hit
    base_mr = 12'd300; b_s = 1; b_a = 1; b_l = 1;
    run_phase(6'd5, 12'd100, 1, 1, -1, 0, 0, 0, "R1");
    run_phase(6'd5, 12'd999, 0, 0, 0, 0, 0, 0, "R2");

    // R6 clamp both ends
    b_s = 2; b_a = 0; b_l = 2;
    run_phase(6'd6, 12'd400, 0, 3, -3, 1, 0, 0, "R6");
    b_s = 0; b_a = 2; b_l = 0;
    run_phase(6'd7, 12'd50, 2, -1, 1, 2, 0, 0, "R6");

    // R11 ack while idle
    @(negedge clk); win_ack = 1;
    @(posedge clk); #1; win_ack = 0;
    chk(!cfg_valid && !busy, "R11", "idle ack ignored", cfg_valid, 0);

    // R8 request while busy not inserted; R10 base perturbed during wait
    run_phase(6'd20, 12'd10, 3, 1, 1, 1, 1, 6'd21, "R8");
    run_phase(6'd21, 12'd10, 0, 0, 0, 0, 0, 0, "R8");

    // R9 replacement after fresh reset
    do_reset();
    for (int i = 0; i < ENTRIES; i++) run_phase(ID_W'(30 + i), MR_W'(i*37), 0, 0, 1, -1, 0, 0, "R9");
    run_phase(6'd38, 12'd77, 0, 1, 0, 0, 0, 0, "R9");
    chk(find(6'd30) < 0, "R9", "model evicted oldest", find(6'd30), -1);
    run_phase(6'd31, 12'd5, 0, 0, 0, 0, 0, 0, "R9");
    run_phase(6'd30, 12'd5, 0, 0, 0, 0, 0, 0, "R9");
    run_phase(6'd32, 12'd5, 0, 0, 0, 0, 0, 0, "R9");

    // random mix
    for (int n = 0; n < 400; n++) begin
      if ($urandom % 4 == 0) begin
        @(negedge clk);
        base_mr = MR_W'($urandom); b_s = LW'($urandom % 3); b_a = LW'($urandom % 3); b_l = LW'($urandom % 3);
      end
      run_phase(ID_W'($urandom % 12), MR_W'($urandom), int'($urandom % 4),
                int'($urandom % 7) - 3, int'($urandom % 7) - 3, int'($urandom % 7) - 3,
                ($urandom % 3 == 0), ID_W'($urandom % 12), "R2 R3");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule